// File: doc/BRIEF.md
# Shared Bus Register Datapath

This block is the transfer fabric of a small accumulator machine: a single 16-bit bus that one source drives at a time and any register or the word memory may capture. A 3-bit select picks the source each cycle, and a set of per-register strobes says who takes the value, who counts up and who clears. The arithmetic unit, instruction decoding and interrupt logic sit outside. A sequencer drives the strobes, and this block carries out the transfers.

The register set has a 12-bit address register, a 12-bit program counter, and 16-bit data, accumulator, instruction and temporary registers. An 8-bit output register takes the low byte of the bus. The memory holds 4096 16-bit words. Writes are synchronous. Reads are combinational, so a word can be fetched and loaded into a register in one cycle. The address register always supplies the memory address.

Top module: `sbusTop`

## Requirements
- R1: The bus source is chosen by `busSel`: 0 gives all zeros, 1 the address register, 2 the program counter, 3 the data register, 4 the accumulator, 5 the instruction register, 6 the temporary register, 7 the memory word.
- R2: When the address register or the program counter drives the bus, bus bits 15..12 are zero and bits 11..0 carry the register.
- R3: On a rising edge with `ldOut` high, the output register takes bus bits 7..0. Otherwise it holds its value.
- R4: On a rising edge with only the load strobe of a register high, that register takes the bus value, truncated to its width.
- R5: When a register sees more than one of its strobes in the same cycle, clear wins over load and load wins over increment.
- R6: Increment adds one modulo the register width, so a 12-bit register steps from 0xFFF to 0x000 and a 16-bit one from 0xFFFF to 0x0000.
- R7: The instruction register changes only when `ldInstr` is high. With no strobe high, any register holds its value.
- R8: With `memWr` high, the bus value is stored at the address the address register held before the edge, even if that register changes on the same edge. With `busSel` 7 and `memRd` high, the bus carries the word at the current address.
- R9: While `rstN` is low, every register reads zero and the bus reads zero whatever the select.
- R10: With `busSel` 7 and `memRd` low, the bus reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous reset, active low |
| busSel | input | 3 | Bus source select |
| ldAddr | input | 1 | Load address register |
| incAddr | input | 1 | Increment address register |
| clrAddr | input | 1 | Clear address register |
| ldPc | input | 1 | Load program counter |
| incPc | input | 1 | Increment program counter |
| clrPc | input | 1 | Clear program counter |
| ldData | input | 1 | Load data register |
| incData | input | 1 | Increment data register |
| clrData | input | 1 | Clear data register |
| ldAcc | input | 1 | Load accumulator |
| incAcc | input | 1 | Increment accumulator |
| clrAcc | input | 1 | Clear accumulator |
| ldInstr | input | 1 | Load instruction register |
| ldTemp | input | 1 | Load temporary register |
| incTemp | input | 1 | Increment temporary register |
| clrTemp | input | 1 | Clear temporary register |
| ldOut | input | 1 | Load output register from low bus byte |
| memRd | input | 1 | Let the memory word onto the bus |
| memWr | input | 1 | Store bus value into memory |
| busValue | output | 16 | Current bus value |
| addrReg | output | 12 | Address register |
| pcReg | output | 12 | Program counter |
| dataReg | output | 16 | Data register |
| accReg | output | 16 | Accumulator |
| instrReg | output | 16 | Instruction register |
| tempReg | output | 16 | Temporary register |
| outReg | output | 8 | Output register |

## Verification
A memory write and a change to the address register can land on the same edge. The bench provokes this by writing while it increments, clears or loads the address register, then reads back both the old and the new address, so the stored word must sit at the pre-edge address. A register can also drive the bus while loading or counting in the same cycle. The bench loads the accumulator from its own bus value with increment also asserted, and it runs long random stretches where strobes collide. The behavioural model judges every register and the bus on each clock.

// File: rtl/sbusPkg.sv
package sbusPkg;

  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_CLEAR = 2'd1,
    OP_LOAD  = 2'd2,
    OP_INC   = 2'd3
  } regOpT;

  typedef struct packed {
    regOpT      addrOp;
    regOpT      pcOp;
    regOpT      dataOp;
    regOpT      accOp;
    regOpT      instrOp;
    regOpT      tempOp;
    logic       outLd;
    logic       memRd;
    logic       memWr;
    logic [2:0] sel;
  } strobeT;

  localparam logic [2:0] SEL_NONE  = 3'd0;
  localparam logic [2:0] SEL_ADDR  = 3'd1;
  localparam logic [2:0] SEL_PC    = 3'd2;
  localparam logic [2:0] SEL_DATA  = 3'd3;
  localparam logic [2:0] SEL_ACC   = 3'd4;
  localparam logic [2:0] SEL_INSTR = 3'd5;
  localparam logic [2:0] SEL_TEMP  = 3'd6;
  localparam logic [2:0] SEL_MEM   = 3'd7;

  // clear beats load, load beats increment
  function automatic regOpT resolveOp(input logic clr, input logic ld, input logic inc);
    if (clr)      return OP_CLEAR;
    else if (ld)  return OP_LOAD;
    else if (inc) return OP_INC;
    else          return OP_HOLD;
  endfunction

endpackage

// File: rtl/sbusCtrl.sv
module sbusCtrl
  import sbusPkg::*;
(
  input  logic       busSel_i,
  input  logic [2:0] sel_i,
  input  logic       ldAddr, incAddr, clrAddr,
  input  logic       ldPc, incPc, clrPc,
  input  logic       ldData, incData, clrData,
  input  logic       ldAcc, incAcc, clrAcc,
  input  logic       ldInstr,
  input  logic       ldTemp, incTemp, clrTemp,
  input  logic       ldOut,
  input  logic       memRd,
  input  logic       memWr,
  output strobeT     strobes
);

  logic unusedSel;
  assign unusedSel = busSel_i;

  always_comb begin
    strobes.addrOp  = resolveOp(clrAddr, ldAddr, incAddr);
    strobes.pcOp    = resolveOp(clrPc, ldPc, incPc);
    strobes.dataOp  = resolveOp(clrData, ldData, incData);
    strobes.accOp   = resolveOp(clrAcc, ldAcc, incAcc);
    strobes.instrOp = ldInstr ? OP_LOAD : OP_HOLD;
    strobes.tempOp  = resolveOp(clrTemp, ldTemp, incTemp);
    strobes.outLd   = ldOut;
    strobes.memRd   = memRd;
    strobes.memWr   = memWr;
    strobes.sel     = sel_i;
  end

endmodule

// File: rtl/sbusReg.sv
module sbusReg
  import sbusPkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rstN,
  input  regOpT        op,
  input  logic [W-1:0] din,
  output logic [W-1:0] q
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      q <= '0;
    end else begin
      unique case (op)
        OP_CLEAR: q <= '0;
        OP_LOAD:  q <= din;
        OP_INC:   q <= q + W'(1);
        default:  q <= q;
      endcase
    end
  end

endmodule

// File: rtl/sbusPath.sv
module sbusPath
  import sbusPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobeT            strobes,
  output logic [WORD_W-1:0] busValue,
  output logic [ADDR_W-1:0] addrReg,
  output logic [ADDR_W-1:0] pcReg,
  output logic [WORD_W-1:0] dataReg,
  output logic [WORD_W-1:0] accReg,
  output logic [WORD_W-1:0] instrReg,
  output logic [WORD_W-1:0] tempReg,
  output logic [OUT_W-1:0]  outReg
);

  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAD_W = WORD_W - ADDR_W;

  logic [WORD_W-1:0] memArr [DEPTH];
  logic [WORD_W-1:0] memWord;
  logic [WORD_W-1:0] busMux;

  // narrow registers: one instance per address-width register
  localparam int NARROW_N = 2;
  regOpT             narrowOp [NARROW_N];
  logic [ADDR_W-1:0] narrowQ  [NARROW_N];
  assign narrowOp[0] = strobes.addrOp;
  assign narrowOp[1] = strobes.pcOp;

  // wide registers: data, accumulator, instruction, temporary
  localparam int WIDE_N = 4;
  regOpT             wideOp [WIDE_N];
  logic [WORD_W-1:0] wideQ  [WIDE_N];
  assign wideOp[0] = strobes.dataOp;
  assign wideOp[1] = strobes.accOp;
  assign wideOp[2] = strobes.instrOp;
  assign wideOp[3] = strobes.tempOp;

  for (genvar n = 0; n < NARROW_N; n++) begin : gNarrow
    sbusReg #(.W(ADDR_W)) reg_i (
      .clk(clk), .rstN(rstN), .op(narrowOp[n]),
      .din(busValue[ADDR_W-1:0]), .q(narrowQ[n])
    );
  end

  for (genvar w = 0; w < WIDE_N; w++) begin : gWide
    sbusReg #(.W(WORD_W)) reg_i (
      .clk(clk), .rstN(rstN), .op(wideOp[w]),
      .din(busValue), .q(wideQ[w])
    );
  end

  sbusReg #(.W(OUT_W)) outReg_i (
    .clk(clk), .rstN(rstN),
    .op(strobes.outLd ? OP_LOAD : OP_HOLD),
    .din(busValue[OUT_W-1:0]), .q(outReg)
  );

  assign addrReg  = narrowQ[0];
  assign pcReg    = narrowQ[1];
  assign dataReg  = wideQ[0];
  assign accReg   = wideQ[1];
  assign instrReg = wideQ[2];
  assign tempReg  = wideQ[3];

  // memory: synchronous write at the pre-edge address, combinational read
  always_ff @(posedge clk) begin
    if (rstN && strobes.memWr) memArr[addrReg] <= busValue;
  end
  assign memWord = memArr[addrReg];

  always_comb begin
    unique case (strobes.sel)
      SEL_ADDR:  busMux = {{PAD_W{1'b0}}, addrReg};
      SEL_PC:    busMux = {{PAD_W{1'b0}}, pcReg};
      SEL_DATA:  busMux = dataReg;
      SEL_ACC:   busMux = accReg;
      SEL_INSTR: busMux = instrReg;
      SEL_TEMP:  busMux = tempReg;
      SEL_MEM:   busMux = strobes.memRd ? memWord : '0;
      default:   busMux = '0;
    endcase
  end

  assign busValue = rstN ? busMux : '0;

endmodule

// File: rtl/sbusTop.sv
module sbusTop
  import sbusPkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [2:0]        busSel,
  input  logic              ldAddr,
  input  logic              incAddr,
  input  logic              clrAddr,
  input  logic              ldPc,
  input  logic              incPc,
  input  logic              clrPc,
  input  logic              ldData,
  input  logic              incData,
  input  logic              clrData,
  input  logic              ldAcc,
  input  logic              incAcc,
  input  logic              clrAcc,
  input  logic              ldInstr,
  input  logic              ldTemp,
  input  logic              incTemp,
  input  logic              clrTemp,
  input  logic              ldOut,
  input  logic              memRd,
  input  logic              memWr,
  output logic [WORD_W-1:0] busValue,
  output logic [ADDR_W-1:0] addrReg,
  output logic [ADDR_W-1:0] pcReg,
  output logic [WORD_W-1:0] dataReg,
  output logic [WORD_W-1:0] accReg,
  output logic [WORD_W-1:0] instrReg,
  output logic [WORD_W-1:0] tempReg,
  output logic [OUT_W-1:0]  outReg
);

  strobeT strobes;

  sbusCtrl ctrl_i (
    .busSel_i(1'b0), .sel_i(busSel),
    .ldAddr(ldAddr), .incAddr(incAddr), .clrAddr(clrAddr),
    .ldPc(ldPc), .incPc(incPc), .clrPc(clrPc),
    .ldData(ldData), .incData(incData), .clrData(clrData),
    .ldAcc(ldAcc), .incAcc(incAcc), .clrAcc(clrAcc),
    .ldInstr(ldInstr),
    .ldTemp(ldTemp), .incTemp(incTemp), .clrTemp(clrTemp),
    .ldOut(ldOut), .memRd(memRd), .memWr(memWr),
    .strobes(strobes)
  );

  sbusPath #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OUT_W(OUT_W)) path_i (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .busValue(busValue), .addrReg(addrReg), .pcReg(pcReg),
    .dataReg(dataReg), .accReg(accReg), .instrReg(instrReg),
    .tempReg(tempReg), .outReg(outReg)
  );

endmodule

// File: rtl/sbusChecker.sv
module sbusChecker #(
  parameter int ADDR_W = 12,
  parameter int WORD_W = 16,
  parameter int OUT_W  = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [2:0]        busSel,
  input logic              clrAcc,
  input logic              ldAcc,
  input logic              incPc,
  input logic              ldPc,
  input logic              clrPc,
  input logic              ldInstr,
  input logic              ldOut,
  input logic              memRd,
  input logic [WORD_W-1:0] busValue,
  input logic [ADDR_W-1:0] pcReg,
  input logic [WORD_W-1:0] accReg,
  input logic [WORD_W-1:0] instrReg,
  input logic [OUT_W-1:0]  outReg
);

  AST_NARROW_PAD: assert property (@(posedge clk) disable iff (!rstN)
    (busSel == 3'd1 || busSel == 3'd2) |-> busValue[WORD_W-1:ADDR_W] == '0); // R2
  AST_OUT_LOW_BYTE: assert property (@(posedge clk) disable iff (!rstN)
    ldOut |=> outReg == $past(busValue[OUT_W-1:0])); // R3
  AST_ACC_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    (ldAcc && !clrAcc) |=> accReg == $past(busValue)); // R4
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rstN)
    clrAcc |=> accReg == '0); // R5
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (incPc && !ldPc && !clrPc) |=> pcReg == $past(pcReg) + ADDR_W'(1)); // R6
  AST_INSTR_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !ldInstr |=> $stable(instrReg)); // R7
  AST_IDLE_BUS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busSel == 3'd0 || (busSel == 3'd7 && !memRd)) |-> busValue == '0); // R10
  AST_RESET_BUS: assert property (@(posedge clk)
    !rstN |-> busValue == '0); // R9

endmodule

bind sbusTop sbusChecker #(.ADDR_W(ADDR_W), .WORD_W(WORD_W), .OUT_W(OUT_W)) chk_i (
  .clk(clk), .rstN(rstN), .busSel(busSel), .clrAcc(clrAcc), .ldAcc(ldAcc),
  .incPc(incPc), .ldPc(ldPc), .clrPc(clrPc), .ldInstr(ldInstr), .ldOut(ldOut),
  .memRd(memRd), .busValue(busValue), .pcReg(pcReg), .accReg(accReg),
  .instrReg(instrReg), .outReg(outReg)
);

// File: tb/sbusTop_tb_top.sv
module sbusTop_tb_top;

  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [2:0] busSel = '0;
  logic ldAddr = 0, incAddr = 0, clrAddr = 0;
  logic ldPc = 0, incPc = 0, clrPc = 0;
  logic ldData = 0, incData = 0, clrData = 0;
  logic ldAcc = 0, incAcc = 0, clrAcc = 0;
  logic ldInstr = 0;
  logic ldTemp = 0, incTemp = 0, clrTemp = 0;
  logic ldOut = 0, memRd = 0, memWr = 0;

  logic [15:0] busValue, dataReg, accReg, instrReg, tempReg;
  logic [11:0] addrReg, pcReg;
  logic [7:0]  outReg;

  always #(CLK_PERIOD/2) clk = ~clk;

  sbusTop dut_i (
    .clk(clk), .rstN(rstN), .busSel(busSel),
    .ldAddr(ldAddr), .incAddr(incAddr), .clrAddr(clrAddr),
    .ldPc(ldPc), .incPc(incPc), .clrPc(clrPc),
    .ldData(ldData), .incData(incData), .clrData(clrData),
    .ldAcc(ldAcc), .incAcc(incAcc), .clrAcc(clrAcc),
    .ldInstr(ldInstr), .ldTemp(ldTemp), .incTemp(incTemp), .clrTemp(clrTemp),
    .ldOut(ldOut), .memRd(memRd), .memWr(memWr),
    .busValue(busValue), .addrReg(addrReg), .pcReg(pcReg), .dataReg(dataReg),
    .accReg(accReg), .instrReg(instrReg), .tempReg(tempReg), .outReg(outReg)
  );

  // behavioural model state
  int modAddr, modPc, modData, modAcc, modInstr, modTemp, modOut;
  int modMem [int];
  string tagAddr = "R9", tagPc = "R9", tagData = "R9", tagAcc = "R9";
  string tagInstr = "R9", tagTemp = "R9", tagOut = "R9";
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 0;

  task automatic check(input string tag, input string what, input int actual, input int expected);
    testsRun++;
    if (actual != expected) begin
      testsFailed++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, actual, expected);
    end
  endtask

  function automatic string opTag(input bit clr, input bit ld, input bit inc);
    if ((clr && (ld || inc)) || (ld && inc)) return "R5";
    if (clr) return "R5";
    if (inc) return "R6";
    return "R4";
  endfunction

  function automatic int stepReg(input int cur, input bit clr, input bit ld, input bit inc,
                                 input int bv, input int mask);
    if (clr) return 0;
    if (ld)  return bv & mask;
    if (inc) return (cur + 1) & mask;
    return cur;
  endfunction

  function automatic int expBus();
    if (!rstN) return 0;
    case (busSel)
      3'd1: return modAddr;
      3'd2: return modPc;
      3'd3: return modData;
      3'd4: return modAcc;
      3'd5: return modInstr;
      3'd6: return modTemp;
      3'd7: return memRd ? (modMem.exists(modAddr) ? modMem[modAddr] : -1) : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string busTag();
    if (!rstN) return "R9";
    if (busSel == 3'd1 || busSel == 3'd2) return "R2";
    if (busSel == 3'd7) return memRd ? "R8" : "R10";
    return "R1";
  endfunction

  task automatic compareRegs();
    check(tagAddr,  "addrReg",  int'(addrReg),  modAddr);
    check(tagPc,    "pcReg",    int'(pcReg),    modPc);
    check(tagData,  "dataReg",  int'(dataReg),  modData);
    check(tagAcc,   "accReg",   int'(accReg),   modAcc);
    check(tagInstr, "instrReg", int'(instrReg), modInstr);
    check(tagTemp,  "tempReg",  int'(tempReg),  modTemp);
    check(tagOut,   "outReg",   int'(outReg),   modOut);
  endtask

  task automatic idle();
    busSel = 0;
    {ldAddr, incAddr, clrAddr, ldPc, incPc, clrPc} = '0;
    {ldData, incData, clrData, ldAcc, incAcc, clrAcc} = '0;
    {ldInstr, ldTemp, incTemp, clrTemp, ldOut, memRd, memWr} = '0;
  endtask

  // inputs are already set; compare bus, advance one edge, update model, compare registers
  task automatic cycle();
    int bv;
    #1;
    bv = expBus();
    if (bv >= 0) check(busTag(), "busValue", int'(busValue), bv);
    else bv = int'(busValue);
    @(posedge clk);
    if (rstN) begin
      if (memWr) modMem[modAddr] = bv;
      modAddr  = stepReg(modAddr, clrAddr, ldAddr, incAddr, bv, 'hFFF);
      tagAddr  = memWr ? "R8" : opTag(clrAddr, ldAddr, incAddr);
      modPc    = stepReg(modPc, clrPc, ldPc, incPc, bv, 'hFFF);
      tagPc    = opTag(clrPc, ldPc, incPc);
      modData  = stepReg(modData, clrData, ldData, incData, bv, 'hFFFF);
      tagData  = opTag(clrData, ldData, incData);
      modAcc   = stepReg(modAcc, clrAcc, ldAcc, incAcc, bv, 'hFFFF);
      tagAcc   = opTag(clrAcc, ldAcc, incAcc);
      modTemp  = stepReg(modTemp, clrTemp, ldTemp, incTemp, bv, 'hFFFF);
      tagTemp  = opTag(clrTemp, ldTemp, incTemp);
      modInstr = stepReg(modInstr, 1'b0, ldInstr, 1'b0, bv, 'hFFFF);
      tagInstr = "R7";
      modOut   = stepReg(modOut, 1'b0, ldOut, 1'b0, bv, 'hFF);
      tagOut   = "R3";
    end
    @(negedge clk);
    compareRegs();
    idle();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      testsFailed++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    modAddr = 0; modPc = 0; modData = 0; modAcc = 0;
    modInstr = 0; modTemp = 0; modOut = 0;
    idle();
    // R9: reset holds everything at zero, bus zero even with a source selected
    @(negedge clk);
    busSel = 3'd4; incAcc = 1; ldOut = 1;
    cycle();
    rstN = 1'b1;
    // R6: count accumulator to 3
    repeat (3) begin incAcc = 1; cycle(); end
    // R4: address register from accumulator
    busSel = 3'd4; ldAddr = 1; cycle();
    // R8: write accumulator to memory while address register increments
    busSel = 3'd4; memWr = 1; incAddr = 1; cycle();
    // R8: read back at old address, new address holds nothing written
    clrAddr = 1; cycle();
    repeat (3) begin incAddr = 1; cycle(); end
    busSel = 3'd7; memRd = 1; ldData = 1; cycle();
    // R10: memory select without read strobe gives zero
    busSel = 3'd7; ldTemp = 1; cycle();
    // R5: clear beats load and increment, then load beats increment
    busSel = 3'd3; clrAcc = 1; ldAcc = 1; incAcc = 1; cycle();
    busSel = 3'd3; ldAcc = 1; incAcc = 1; cycle();
    // R4/R5: accumulator reloads from its own bus value while incrementing
    busSel = 3'd4; ldAcc = 1; incAcc = 1; cycle();
    // R3: output byte from 0x01AB
    repeat (16'h01A8) begin incAcc = 1; cycle(); end
    busSel = 3'd4; ldOut = 1; ldInstr = 1; cycle();
    // R6: program counter wraps 0xFFF -> 0x000; R2 checked on bus at 0xFFF
    repeat (4095) begin incPc = 1; cycle(); end
    busSel = 3'd2; ldTemp = 1; cycle();
    incPc = 1; cycle();
    // R6: accumulator 16-bit wrap
    clrAcc = 1; cycle();
    repeat (65535) begin incAcc = 1; cycle(); end
    busSel = 3'd4; ldData = 1; cycle();
    incAcc = 1; cycle();
    // R7: instruction register untouched under other strobes
    busSel = 3'd3; ldAcc = 1; incTemp = 1; cycle();
    // mixed random traffic with colliding strobes
    for (int i = 0; i < 4000; i++) begin
      busSel = 3'($urandom);
      {ldAddr, incAddr, clrAddr} = {($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 9 == 0)};
      {ldPc, incPc, clrPc}       = {($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 9 == 0)};
      {ldData, incData, clrData} = {($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 9 == 0)};
      {ldAcc, incAcc, clrAcc}    = {($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 9 == 0)};
      {ldTemp, incTemp, clrTemp} = {($urandom % 5 == 0), ($urandom % 3 == 0), ($urandom % 9 == 0)};
      ldInstr = ($urandom % 6 == 0);
      ldOut   = ($urandom % 6 == 0);
      memWr   = ($urandom % 4 == 0);
      memRd   = ($urandom % 2 == 0) && modMem.exists(modAddr);
      cycle();
    end
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule